// File: doc/BRIEF.md
# Interlocked Parallel Byte Handshake Port

This block moves bytes across one 8-bit parallel port using two handshake wires: an active-low "byte present" strobe and an active-high "ready" line. A single mode bit selects the direction. As a receiver, the block watches the sender's strobe. It captures the byte on the strobe's falling edge and pulls its ready line low. It keeps that line low until the strobe has gone high again and the core has acknowledged the byte.

As a transmitter, the block first drives the byte onto the port. It lowers its strobe once the far side's ready line is high, and raises the strobe only after ready has fallen. It takes no new byte until ready has risen again.

Every handshake step waits for the other party's previous step, so a transfer always follows four edges: strobe falls, ready falls, strobe rises, ready rises. Both incoming handshake lines pass through a two-stage synchronizer before the block acts on them. Switching the mode bit aborts a transmit that is in progress.

Top module: `pp_handshake`

## Requirements
- R1: While reset is held and in the first cycle after it, dav_n_out and rdy_out are 1 and rd_new is 0. In receive mode (mode_out=0), port_doe is 0. In transmit mode, wr_busy is 0.
- R2: In receive mode, the block detects a 1-to-0 transition of dav_n_in after synchronization. It then loads port_din into rd_data and sets rd_new. rdy_out goes to 0 on the third rising clock edge after the transition, and not earlier.
- R3: In receive mode, rdy_out stays 0 while rd_new is 1, even after dav_n_in has returned high.
- R4: In receive mode, rdy_out returns to 1 only when the synchronized dav_n_in is 1 and rd_new has been cleared. A 1 on rd_ack clears rd_new.
- R5: In receive mode, the block never drives the port: port_doe is 0 and dav_n_out is 1.
- R6: In transmit mode (mode_out=1), wr_valid with wr_busy=0 captures wr_data. port_dout shows the byte with port_doe=1 at least one cycle before dav_n_out falls, and the byte stays unchanged while dav_n_out is 0.
- R7: In transmit mode, dav_n_out falls only when the synchronized rdy_in is 1. While rdy_in is held low, dav_n_out stays 1.
- R8: In transmit mode, dav_n_out returns to 1 only after the synchronized rdy_in has gone to 0.
- R9: In transmit mode, wr_busy stays 1 from acceptance until rdy_in has risen again after dav_n_out rose. A wr_valid while busy is ignored, and port_dout keeps the earlier byte.
- R10: In transmit mode, rdy_out is held at 1. In receive mode, wr_busy is held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_out | input | 1 | 1 = transmit channel, 0 = receive channel |
| wr_data | input | 8 | Byte to transmit |
| wr_valid | input | 1 | Core offers wr_data |
| wr_busy | output | 1 | Write refused while 1 |
| rd_data | output | 8 | Last received byte |
| rd_new | output | 1 | Received byte not yet acknowledged |
| rd_ack | input | 1 | Core consumed rd_data |
| port_din | input | 8 | Port data lines, receive direction |
| port_dout | output | 8 | Port data lines, transmit direction |
| port_doe | output | 1 | Drive enable for port_dout |
| dav_n_in | input | 1 | Sender's active-low byte-present strobe |
| dav_n_out | output | 1 | Own active-low byte-present strobe |
| rdy_in | input | 1 | Receiver's ready line |
| rdy_out | output | 1 | Own ready line |

## Verification
A receive state machine stuck in its busy state shows up at the port as rdy_out held low. The sender stalls, and the next byte's strobe never produces a capture within the few cycles allowed.

A transmit machine that skips a step shows up at once as a strobe edge that is not preceded by the matching edge on rdy_in. It can also show up as wr_busy dropping while ready is still low. The bench receiver model catches both within two or three cycles.

A wrongly latched byte surfaces on rd_data or port_dout at the first compare after the strobe edge.

// File: rtl/pph_pkg.sv
// Shared state encodings for the interlocked parallel handshake port.
package pph_pkg;

    typedef enum logic {
        RX_IDLE,
        RX_BUSY
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,   // waiting for a byte from the core
        TX_ARM,    // byte on the port, waiting for ready high
        TX_HELD,   // strobe low, waiting for ready low
        TX_DRAIN   // strobe released, waiting for ready high again
    } tx_state_t;

endpackage

// File: rtl/pph_sync.sv
// Multi-stage synchronizer for asynchronous handshake lines.
// Assumes idle level of every line is high; resets all stages to 1.
module pph_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw line.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= '1;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // Later stages shift the sample forward.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[LAST];
endmodule

// File: rtl/pph_rx.sv
// Receive engine: captures a byte on the falling edge of the synchronized
// strobe, drops ready, and releases ready only after the strobe is high
// again and the core has acknowledged the byte. Assumes the sender holds
// port data stable until ready falls. State persists across mode changes;
// new captures start only while enabled.
module pph_rx
    import pph_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dav_s,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_new,
    output logic              rdy
);
    rx_state_t state;
    logic      dav_q;
    logic      dav_fall;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dav_q <= 1'b1;
        else        dav_q <= dav_s;
    end

    assign dav_fall = en && dav_q && !dav_s;

    // Handshake sequencing, byte capture and unread flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            rd_data <= '0;
            rd_new  <= 1'b0;
        end else begin
            case (state)
                RX_IDLE: begin
                    if (dav_fall) begin
                        state   <= RX_BUSY;
                        rd_data <= din;
                        rd_new  <= 1'b1;
                    end
                end
                RX_BUSY: begin
                    if (dav_s && !rd_new) state <= RX_IDLE;
                    if (rd_ack)           rd_new <= 1'b0;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign rdy = (state == RX_IDLE);

    a_r3_rdy_low_while_unread: assert property (@(posedge clk) disable iff (!rst_n)
        rd_new |-> !rdy);

    a_r2_capture_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_new) |-> ($past(dav_q) && !$past(dav_s)));

    a_r4_release_after_rise_and_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> ($past(dav_s) && !$past(rd_new)));
endmodule

// File: rtl/pph_tx.sv
// Transmit engine: drives the byte, lowers the strobe once ready is high,
// raises it after ready falls, and frees itself after ready rises again.
// Dropping en aborts any transfer and releases the strobe.
module pph_tx
    import pph_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    input  logic              rdy_s,
    output logic [DATA_W-1:0] dout,
    output logic              dav_n,
    output logic              busy
);
    tx_state_t state;

    // Byte register, written only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)                                dout <= '0;
        else if (en && state == TX_IDLE && wr_valid) dout <= wr_data;
    end

    // Four-edge interlocked strobe sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state <= TX_IDLE;
            dav_n <= 1'b1;
        end else begin
            case (state)
                TX_IDLE:  if (wr_valid) state <= TX_ARM;
                TX_ARM:   if (rdy_s) begin
                              state <= TX_HELD;
                              dav_n <= 1'b0;
                          end
                TX_HELD:  if (!rdy_s) begin
                              state <= TX_DRAIN;
                              dav_n <= 1'b1;
                          end
                TX_DRAIN: if (rdy_s) state <= TX_IDLE;
                default:  state <= TX_IDLE;
            endcase
        end
    end

    assign busy = (state != TX_IDLE);

    a_r7_fall_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dav_n) |-> $past(rdy_s));

    a_r8_rise_needs_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dav_n) && $past(en)) |-> !$past(rdy_s));

    a_r9_busy_while_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
        !dav_n |-> busy);

    a_r6_data_steady_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !dav_n |-> $stable(dout));
endmodule

// File: rtl/pp_handshake.sv
// Top of the parallel handshake port: synchronizes the incoming strobe
// and ready lines, runs the receive or transmit engine per mode_out, and
// steers the outgoing handshake lines. Assumes dav_n_in/rdy_in pulses last
// longer than the synchronizer depth plus one cycle.
module pp_handshake #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_out,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_new,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] port_din,
    output logic [DATA_W-1:0] port_dout,
    output logic              port_doe,
    input  logic              dav_n_in,
    output logic              dav_n_out,
    input  logic              rdy_in,
    output logic              rdy_out
);
    localparam int HS_LINES = 2;

    logic [HS_LINES-1:0] hs_sync;
    logic                dav_s;
    logic                rdy_s;
    logic                rx_rdy;
    logic                tx_dav_n;
    logic                tx_busy;

    pph_sync #(.WIDTH(HS_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dav_n_in, rdy_in}),
        .q     (hs_sync)
    );

    assign dav_s = hs_sync[1];
    assign rdy_s = hs_sync[0];

    pph_rx #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (!mode_out),
        .dav_s   (dav_s),
        .din     (port_din),
        .rd_ack  (rd_ack),
        .rd_data (rd_data),
        .rd_new  (rd_new),
        .rdy     (rx_rdy)
    );

    pph_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mode_out),
        .wr_data  (wr_data),
        .wr_valid (wr_valid),
        .rdy_s    (rdy_s),
        .dout     (port_dout),
        .dav_n    (tx_dav_n),
        .busy     (tx_busy)
    );

    // Steer handshake outputs by direction.
    always_comb begin
        port_doe  = mode_out;
        dav_n_out = mode_out ? tx_dav_n : 1'b1;
        rdy_out   = mode_out ? 1'b1     : rx_rdy;
        wr_busy   = mode_out ? tx_busy  : 1'b1;
    end

    a_r5_receive_mode_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_out && $past(!mode_out)) |-> (dav_n_out && !port_doe));
endmodule

// File: tb/pp_handshake_test.sv
// Scoreboard bench: driver tasks queue expected bytes; a core-side monitor
// checks received bytes, and a receiver model checks transmitted bytes.
module pp_handshake_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_out = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_valid = 1'b0;
    logic       wr_busy;
    logic [7:0] rd_data;
    logic       rd_new;
    logic       rd_ack = 1'b0;
    logic [7:0] port_din = '0;
    logic [7:0] port_dout;
    logic       port_doe;
    logic       dav_n_in = 1'b1;
    logic       dav_n_out;
    logic       rdy_in;
    logic       rdy_out;

    logic       model_rdy = 1'b1;
    logic       hold_rdy_low = 1'b0;
    assign rdy_in = model_rdy & ~hold_rdy_low;

    int checks = 0;
    int errors = 0;
    int ack_delay = 0;
    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];

    always #5 clk = ~clk;

    pp_handshake uut (
        .clk(clk), .rst_n(rst_n), .mode_out(mode_out),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_busy(wr_busy),
        .rd_data(rd_data), .rd_new(rd_new), .rd_ack(rd_ack),
        .port_din(port_din), .port_dout(port_dout), .port_doe(port_doe),
        .dav_n_in(dav_n_in), .dav_n_out(dav_n_out),
        .rdy_in(rdy_in), .rdy_out(rdy_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    // Core-side monitor: compare each received byte, then acknowledge.
    initial begin
        forever begin
            @(negedge clk);
            if (!mode_out && rst_n && rd_new && !rd_ack) begin
                if (rx_q.size() == 0) chk(1'b0, "R2 unexpected byte", rd_data, 0);
                else begin
                    logic [7:0] e;
                    e = rx_q.pop_front();
                    chk(rd_data == e, "R2 captured byte", rd_data, e);
                end
                repeat (ack_delay) @(negedge clk);
                rd_ack = 1'b1;
                @(negedge clk);
                rd_ack = 1'b0;
            end
        end
    end

    // Far-end receiver model for transmit mode.
    initial begin
        forever begin
            @(negedge clk);
            if (mode_out && rst_n && dav_n_out == 1'b0 && model_rdy) begin
                if (tx_q.size() == 0) chk(1'b0, "R6 unexpected strobe", port_dout, 0);
                else begin
                    logic [7:0] e;
                    e = tx_q.pop_front();
                    chk(port_dout == e && port_doe, "R6 byte under strobe", port_dout, e);
                end
                repeat (2) @(negedge clk);
                chk(dav_n_out == 1'b0, "R8 strobe held before ready falls", dav_n_out, 0);
                model_rdy = 1'b0;
                for (int i = 0; i < 20 && dav_n_out == 1'b0; i++) @(negedge clk);
                repeat (4) @(negedge clk);
                model_rdy = 1'b1;
            end
        end
    end

    // Drive one receive transfer through the sender side.
    task automatic send_rx(input logic [7:0] b, input bit slow);
        @(negedge clk);
        rx_q.push_back(b);
        port_din = b;
        dav_n_in = 1'b0;
        repeat (2) @(negedge clk);
        chk(rdy_out == 1'b1, "R2 ready not early", rdy_out, 1);
        @(negedge clk);
        chk(rdy_out == 1'b0 && rd_new == 1'b1, "R2 ready low after 3 edges", {rdy_out, rd_new}, 2'b01);
        chk(dav_n_out == 1'b1 && port_doe == 1'b0, "R5 no drive in receive", {dav_n_out, port_doe}, 2'b10);
        port_din = ~b;
        dav_n_in = 1'b1;
        if (slow) begin
            repeat (8) @(negedge clk);
            chk(rdy_out == 1'b0 && rd_new == 1'b1, "R3 ready held until ack", {rdy_out, rd_new}, 2'b01);
        end
        for (int i = 0; i < 40 && rdy_out == 1'b0; i++) @(negedge clk);
        chk(rdy_out == 1'b1 && rd_new == 1'b0, "R4 ready back after rise and ack", {rdy_out, rd_new}, 2'b10);
        chk(rd_data == b, "R2 byte kept after lines change", rd_data, b);
    endtask

    // Drive one transmit transfer from the core side.
    task automatic send_tx(input logic [7:0] b, input bit hold);
        if (hold) hold_rdy_low = 1'b1;
        @(negedge clk);
        tx_q.push_back(b);
        wr_data  = b;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(wr_busy == 1'b1, "R9 busy on accept", wr_busy, 1);
        chk(port_dout == b && port_doe && dav_n_out, "R6 byte before strobe", port_dout, b);
        if (hold) begin
            repeat (10) @(negedge clk);
            chk(dav_n_out == 1'b1, "R7 strobe waits for ready", dav_n_out, 1);
            hold_rdy_low = 1'b0;
        end
        for (int i = 0; i < 20 && dav_n_out == 1'b1; i++) @(negedge clk);
        chk(dav_n_out == 1'b0, "R7 strobe falls with ready high", dav_n_out, 0);
        for (int i = 0; i < 30 && dav_n_out == 1'b0; i++) @(negedge clk);
        chk(wr_busy == 1'b1 && rdy_in == 1'b0, "R9 busy until ready rises", wr_busy, 1);
        wr_data  = ~b;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        for (int i = 0; i < 30 && wr_busy == 1'b1; i++) @(negedge clk);
        chk(wr_busy == 1'b0, "R9 free after ready rises", wr_busy, 0);
        chk(port_dout == b, "R9 write while busy ignored", port_dout, b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(dav_n_out && rdy_out && !rd_new && !port_doe, "R1 reset state",
            {dav_n_out, rdy_out, rd_new, port_doe}, 4'b1100);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dav_n_out && rdy_out && !rd_new && !port_doe, "R1 after reset",
            {dav_n_out, rdy_out, rd_new, port_doe}, 4'b1100);
        chk(wr_busy == 1'b1, "R10 busy in receive mode", wr_busy, 1);

        ack_delay = 0;
        send_rx(8'hA5, 1'b0);
        send_rx(8'h3C, 1'b0);
        send_rx(8'h00, 1'b0);
        send_rx(8'hFF, 1'b0);
        ack_delay = 15;
        send_rx(8'h96, 1'b1);
        ack_delay = 0;
        repeat (4) @(negedge clk);
        chk(rx_q.size() == 0, "R2 all bytes seen", rx_q.size(), 0);

        mode_out = 1'b1;
        @(negedge clk);
        chk(wr_busy == 1'b0 && rdy_out == 1'b1, "R1 R10 transmit idle", {wr_busy, rdy_out}, 2'b01);
        send_tx(8'h5A, 1'b1);
        send_tx(8'hC3, 1'b0);
        send_tx(8'h81, 1'b0);
        repeat (4) @(negedge clk);
        chk(tx_q.size() == 0, "R6 all bytes seen", tx_q.size(), 0);
        finish_run();
    end
endmodule